// File: doc/BRIEF.md
# Dual-Speed Clock Enable Generator

This block derives every timing pulse of a small controller from one free-running oscillator clock. It produces one CPU clock enable and eight peripheral clock enables. All of them are single-cycle enables in the oscillator domain, not gated clocks. Two rates are supported. In standard rate the oscillator is halved, so a machine cycle spans 12 oscillator periods. In double rate the halving stage is bypassed, so a machine cycle spans 6. A main speed bit picks the rate for the CPU. Each peripheral has its own bit that keeps it at standard rate while the CPU runs at double rate. Idle and power-down requests gate the enables.

Two state machines drive the outputs. The rate machine has the states MODE_STD and MODE_FAST. It moves through STD_TO_FAST or FAST_TO_STD only in a cycle where the halving flop is low, so the change lands on a rising edge of the halved clock. The power machine has the states PWR_RUN, PWR_IDLE and PWR_DOWN. Its transitions are ENTER_DOWN (power-down request, which has priority), ENTER_IDLE (idle request alone) and WAKE (no request). Each of them is taken from any state on the next oscillator edge.

Top module: `dual_speed_ce_gen`

## Requirements
- R1: After reset, control register 0 reads `{7'b0, boot_fast}` and control register 1 reads 0x00. The rate machine starts in double rate exactly when `boot_fast` is high.
- R2: With the main speed bit (register 0 bit 0) clear, `cpu_ce` and every `periph_ce` bit are high in every second oscillator cycle. That is 8 pulses in any 16-cycle window, and `cpu_ce` is never high in two consecutive cycles.
- R3: With the main speed bit set and power state run, `cpu_ce` is high in every cycle. A peripheral whose speed bit is 0 is enabled every cycle, and one whose speed bit is 1 is enabled every second cycle.
- R4: While the main speed bit is clear, the peripheral speed bits have no effect on any enable.
- R5: Writing `wr_data` with `wr_addr`=0 loads register 0. In register 0, bit 1 controls `periph_ce[0]` (timer 0), bit 2 controls `periph_ce[1]` (timer 1), bit 3 controls `periph_ce[2]` (timer 2), bit 4 controls `periph_ce[3]` (serial port), bit 5 controls `periph_ce[4]` (capture array), bit 6 controls `periph_ce[5]` (watchdog) and bit 7 controls `periph_ce[6]` (CAN). With `wr_addr`=1, bit 0 of register 1 controls `periph_ce[7]` (SPI).
- R6: The rate changes only on an oscillator edge at which the halving flop rises. A main-bit write taken at edge E is in force after E+1 if the halving flop was high before E, and after E+2 otherwise.
- R7: Bits 7..1 of register 1 always read 0, whatever is written to them.
- R8: While `idle_req` is high, `cpu_ce` stays low and the peripheral enables keep their rates. Entry and exit take one cycle.
- R9: While `pdown_req` is high, all enables stay low, even if `idle_req` is also high. Entry and exit take one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_fast | input | 1 | Hardware selection of double rate out of reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 = control 0, 1 = control 1 |
| wr_data | input | 8 | Write data |
| idle_req | input | 1 | Idle request (level) |
| pdown_req | input | 1 | Power-down request (level) |
| ctl0_rd | output | 8 | Control register 0 contents |
| ctl1_rd | output | 8 | Control register 1 contents |
| cpu_ce | output | 1 | CPU clock enable |
| periph_ce | output | 8 | Peripheral clock enables, indexed as in R5 |

## Verification
A rate machine in the wrong state shows at the outputs within one or two cycles. `cpu_ce` either stays high where it should drop every other cycle or starts alternating, so any 16-cycle pulse count is off by eight. A switch taken on the wrong phase moves the first run of consecutive `cpu_ce` pulses by one cycle. The bench checks this against its expected four-cycle pattern for both phases and both directions. A wrong register-to-peripheral mapping or a wrong power state changes the count of at least one enable inside the first window after the write or request.

// File: rtl/dsce_pkg.sv
package dsce_pkg;

    localparam int REG_W      = 8;
    localparam int NUM_PERIPH = 8;

    // Peripheral enable index map
    localparam int PER_TMR0 = 0;
    localparam int PER_TMR1 = 1;
    localparam int PER_TMR2 = 2;
    localparam int PER_UART = 3;
    localparam int PER_PCA  = 4;
    localparam int PER_WDOG = 5;
    localparam int PER_CAN  = 6;
    localparam int PER_SPI  = 7;

    typedef enum logic [0:0] {
        MODE_STD  = 1'b0,
        MODE_FAST = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_IDLE = 2'd1,
        PWR_DOWN = 2'd2
    } pwr_e;

endpackage

// File: rtl/dsce_regs.sv
module dsce_regs
    import dsce_pkg::*;
#(
    parameter int REG_BITS = REG_W,
    parameter int NPER     = NUM_PERIPH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                boot_fast,
    input  logic                wr_en,
    input  logic                wr_addr,
    input  logic [REG_BITS-1:0] wr_data,
    output logic [REG_BITS-1:0] ctl0_q,
    output logic [REG_BITS-1:0] ctl1_q,
    output logic                main_fast,
    output logic [NPER-1:0]     periph_slow
);

    // Peripheral bits that live in register 0 (all but bit 0)
    localparam int CTL0_PER = REG_BITS - 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl0_q <= {{(REG_BITS-1){1'b0}}, boot_fast};
            ctl1_q <= '0;
        end else if (wr_en) begin
            if (!wr_addr) begin
                ctl0_q <= wr_data;
            end else begin
                ctl1_q <= {{(REG_BITS-1){1'b0}}, wr_data[0]};
            end
        end
    end

    assign main_fast = ctl0_q[0];

    for (genvar gi = 0; gi < NPER; gi++) begin : g_slow_map
        if (gi < CTL0_PER) begin : g_ctl0
            assign periph_slow[gi] = ctl0_q[gi+1];
        end else begin : g_ctl1
            assign periph_slow[gi] = ctl1_q[gi-CTL0_PER];
        end
    end

    // R5
    ctl0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> (ctl0_q == $past(wr_data)));

    // R7
    ctl1_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr) |=> (ctl1_q == {{(REG_BITS-1){1'b0}}, $past(wr_data[0])}));

endmodule

// File: rtl/dsce_mode_fsm.sv
module dsce_mode_fsm
    import dsce_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  boot_fast,
    input  logic  main_fast,
    output logic  half_q,
    output mode_e mode_q
);

    mode_e mode_n;
    logic  std_to_fast;
    logic  fast_to_std;

    // Halving flop: its rising edge is the only point where the rate may change
    always_ff @(posedge clk) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= ~half_q;
    end

    assign std_to_fast = !half_q &&  main_fast;
    assign fast_to_std = !half_q && !main_fast;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= boot_fast ? MODE_FAST : MODE_STD;
        else        mode_q <= mode_n;
    end

    always_comb begin
        mode_n = mode_q;
        unique case (mode_q)
            MODE_STD:  if (std_to_fast) mode_n = MODE_FAST;
            MODE_FAST: if (fast_to_std) mode_n = MODE_STD;
            default:   mode_n = MODE_STD;
        endcase
    end

    // R6
    mode_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> ($past(half_q) == 1'b0));

endmodule

// File: rtl/dsce_power_fsm.sv
module dsce_power_fsm
    import dsce_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_req,
    input  logic pdown_req,
    output pwr_e pwr_q,
    output logic cpu_run,
    output logic periph_run
);

    pwr_e pwr_n;
    logic enter_down;
    logic enter_idle;
    logic wake;

    assign enter_down = pdown_req;
    assign enter_idle = !pdown_req && idle_req;
    assign wake       = !pdown_req && !idle_req;

    always_ff @(posedge clk) begin
        if (!rst_n) pwr_q <= PWR_RUN;
        else        pwr_q <= pwr_n;
    end

    always_comb begin
        pwr_n = pwr_q;
        unique case (pwr_q)
            PWR_RUN: begin
                if (enter_down)      pwr_n = PWR_DOWN;
                else if (enter_idle) pwr_n = PWR_IDLE;
            end
            PWR_IDLE: begin
                if (enter_down)      pwr_n = PWR_DOWN;
                else if (wake)       pwr_n = PWR_RUN;
            end
            PWR_DOWN: begin
                if (enter_idle)      pwr_n = PWR_IDLE;
                else if (wake)       pwr_n = PWR_RUN;
            end
            default:                 pwr_n = PWR_RUN;
        endcase
    end

    always_comb begin
        cpu_run    = 1'b0;
        periph_run = 1'b0;
        unique case (pwr_q)
            PWR_RUN:  begin cpu_run = 1'b1; periph_run = 1'b1; end
            PWR_IDLE: begin cpu_run = 1'b0; periph_run = 1'b1; end
            PWR_DOWN: begin cpu_run = 1'b0; periph_run = 1'b0; end
            default:  begin cpu_run = 1'b0; periph_run = 1'b0; end
        endcase
    end

    // R9
    pdown_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pdown_req |=> (pwr_q == PWR_DOWN));

    // R8
    idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && !pdown_req) |=> (pwr_q == PWR_IDLE));

endmodule

// File: rtl/dsce_ce_out.sv
module dsce_ce_out
    import dsce_pkg::*;
#(
    parameter int NPER = NUM_PERIPH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            half_q,
    input  mode_e           mode_q,
    input  logic [NPER-1:0] periph_slow,
    input  logic            cpu_run,
    input  logic            periph_run,
    output logic            cpu_ce,
    output logic [NPER-1:0] periph_ce
);

    logic fast_now;

    assign fast_now = (mode_q == MODE_FAST);
    assign cpu_ce   = cpu_run && (fast_now || half_q);

    for (genvar gi = 0; gi < NPER; gi++) begin : g_per
        logic run_full;
        assign run_full      = fast_now && !periph_slow[gi];
        assign periph_ce[gi] = periph_run && (run_full || half_q);
    end

    // R2
    std_cpu_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STD && cpu_ce) |=> !cpu_ce);

    // R9
    down_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_run |-> (periph_ce == '0 && !cpu_ce));

endmodule

// File: rtl/dual_speed_ce_gen.sv
module dual_speed_ce_gen
    import dsce_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  boot_fast,
    input  logic                  wr_en,
    input  logic                  wr_addr,
    input  logic [REG_W-1:0]      wr_data,
    input  logic                  idle_req,
    input  logic                  pdown_req,
    output logic [REG_W-1:0]      ctl0_rd,
    output logic [REG_W-1:0]      ctl1_rd,
    output logic                  cpu_ce,
    output logic [NUM_PERIPH-1:0] periph_ce
);

    logic                  main_fast;
    logic [NUM_PERIPH-1:0] periph_slow;
    logic                  half_q;
    mode_e                 mode_q;
    pwr_e                  pwr_q;
    logic                  cpu_run;
    logic                  periph_run;

    dsce_regs #(.REG_BITS(REG_W), .NPER(NUM_PERIPH)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_fast   (boot_fast),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .ctl0_q      (ctl0_rd),
        .ctl1_q      (ctl1_rd),
        .main_fast   (main_fast),
        .periph_slow (periph_slow)
    );

    dsce_mode_fsm mode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_fast (boot_fast),
        .main_fast (main_fast),
        .half_q    (half_q),
        .mode_q    (mode_q)
    );

    dsce_power_fsm pwr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_req   (idle_req),
        .pdown_req  (pdown_req),
        .pwr_q      (pwr_q),
        .cpu_run    (cpu_run),
        .periph_run (periph_run)
    );

    dsce_ce_out #(.NPER(NUM_PERIPH)) ce_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .half_q      (half_q),
        .mode_q      (mode_q),
        .periph_slow (periph_slow),
        .cpu_run     (cpu_run),
        .periph_run  (periph_run),
        .cpu_ce      (cpu_ce),
        .periph_ce   (periph_ce)
    );

    // R3
    fast_cpu_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FAST && pwr_q == PWR_RUN) |-> cpu_ce);

    // R8
    idle_cpu_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_q == PWR_IDLE) |-> !cpu_ce);

    // R4
    std_periph_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STD && pwr_q != PWR_DOWN) |-> (periph_ce == {NUM_PERIPH{half_q}}));

endmodule

// File: tb/dual_speed_ce_gen_tb_top.sv
`timescale 1ns/1ps
module dual_speed_ce_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_fast = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       idle_req = 1'b0;
    logic       pdown_req = 1'b0;
    logic [7:0] ctl0_rd;
    logic [7:0] ctl1_rd;
    logic       cpu_ce;
    logic [7:0] periph_ce;

    int checks = 0;
    int failures = 0;
    int cpu_cnt;
    int per_cnt [8];
    logic [7:0] pv;
    int seen [4];

    always #2.5 clk = ~clk;

    dual_speed_ce_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_fast (boot_fast),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .idle_req  (idle_req),
        .pdown_req (pdown_req),
        .ctl0_rd   (ctl0_rd),
        .ctl1_rd   (ctl1_rd),
        .cpu_ce    (cpu_ce),
        .periph_ce (periph_ce)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(input int n);
        cpu_cnt = 0;
        for (int i = 0; i < 8; i++) per_cnt[i] = 0;
        repeat (n) begin
            @(negedge clk);
            cpu_cnt += int'(cpu_ce);
            for (int i = 0; i < 8; i++) per_cnt[i] += int'(periph_ce[i]);
        end
    endtask

    task automatic do_reset(input logic bf);
        @(negedge clk);
        rst_n = 1'b0; boot_fast = bf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Write the main bit at a chosen phase; record cpu_ce at the four negedges after the write edge
    task automatic phase_switch(input logic obs_per0, input logic phase, input logic [7:0] d);
        do @(negedge clk); while ((obs_per0 ? periph_ce[0] : cpu_ce) != phase);
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        seen[0] = int'(cpu_ce);
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            seen[k] = int'(cpu_ce);
        end
    endtask

    initial begin
        do_reset(1'b0);
        check("R1 ctl0 after reset", int'(ctl0_rd), 0);
        check("R1 ctl1 after reset", int'(ctl1_rd), 0);
        measure(16);
        check("R1 R2 cpu pulses standard", cpu_cnt, 8);
        for (int i = 0; i < 8; i++) check("R2 periph pulses standard", per_cnt[i], 8);

        write_reg(1'b1, 8'hFF);
        check("R7 ctl1 upper bits ignored", int'(ctl1_rd), 1);
        write_reg(1'b1, 8'hFE);
        check("R7 ctl1 bit0 cleared", int'(ctl1_rd), 0);

        // Sweep all peripheral bit patterns under both main settings
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 256; p++) begin
                pv = 8'(p);
                write_reg(1'b1, {7'b0, pv[7]});
                write_reg(1'b0, {pv[6:0], m[0]});
                check("R5 ctl0 readback", int'(ctl0_rd), int'({pv[6:0], m[0]}));
                repeat (3) @(negedge clk);
                measure(16);
                check("R2 R3 cpu pulses sweep", cpu_cnt, (m == 1) ? 16 : 8);
                for (int i = 0; i < 8; i++)
                    check("R3 R4 R5 periph pulses sweep", per_cnt[i],
                          (m == 1 && pv[i] == 1'b0) ? 16 : 8);
            end
        end

        // Rate switch alignment, standard to double rate
        write_reg(1'b1, 8'h00);
        write_reg(1'b0, 8'h02);
        repeat (4) @(negedge clk);
        phase_switch(1'b0, 1'b1, 8'h03);
        check("R6 std->fast halving high s0", seen[0], 0);
        check("R6 std->fast halving high s1", seen[1], 1);
        check("R6 std->fast halving high s2", seen[2], 1);
        write_reg(1'b0, 8'h02);
        repeat (4) @(negedge clk);
        phase_switch(1'b0, 1'b0, 8'h03);
        check("R6 std->fast halving low s0", seen[0], 1);
        check("R6 std->fast halving low s1", seen[1], 0);
        check("R6 std->fast halving low s2", seen[2], 1);
        check("R6 std->fast halving low s3", seen[3], 1);

        // Double rate to standard, phase seen through the slowed timer 0 enable
        repeat (4) @(negedge clk);
        phase_switch(1'b1, 1'b1, 8'h02);
        check("R6 fast->std halving high s1", seen[1], 1);
        check("R6 fast->std halving high s2", seen[2], 0);
        check("R6 fast->std halving high s3", seen[3], 1);
        write_reg(1'b0, 8'h03);
        repeat (4) @(negedge clk);
        phase_switch(1'b1, 1'b0, 8'h02);
        check("R6 fast->std halving low s2", seen[2], 1);
        check("R6 fast->std halving low s3", seen[3], 0);

        // Idle and power-down in double rate with all peripherals fast
        write_reg(1'b0, 8'h01);
        repeat (4) @(negedge clk);
        idle_req = 1'b1;
        @(negedge clk);
        check("R8 idle one-cycle entry", int'(cpu_ce), 0);
        measure(16);
        check("R8 idle cpu stopped", cpu_cnt, 0);
        for (int i = 0; i < 8; i++) check("R8 idle periph running", per_cnt[i], 16);
        pdown_req = 1'b1;
        @(negedge clk);
        check("R9 power-down one-cycle entry", int'(periph_ce), 0);
        measure(16);
        check("R9 power-down cpu stopped", cpu_cnt, 0);
        for (int i = 0; i < 8; i++) check("R9 power-down periph stopped", per_cnt[i], 0);
        idle_req = 1'b0; pdown_req = 1'b0;
        @(negedge clk);
        check("R9 wake one-cycle exit", int'(cpu_ce), 1);
        measure(16);
        check("R8 R9 cpu restored", cpu_cnt, 16);

        // Hardware start in double rate
        do_reset(1'b1);
        check("R1 ctl0 boot fast", int'(ctl0_rd), 1);
        check("R1 ctl1 boot fast", int'(ctl1_rd), 0);
        measure(16);
        check("R1 R3 cpu pulses boot fast", cpu_cnt, 16);
        for (int i = 0; i < 8; i++) check("R1 R3 periph pulses boot fast", per_cnt[i], 16);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule